// File: doc/BRIEF.md
# Next-PC Jump and Branch Unit

This block holds the program counter of a 32-bit RISC core and decides where it goes next. Each cycle it may receive one decoded instruction word together with the values of its two source registers (A and B). From the top four bits of the word it picks one of these outcomes:

- step to the next sequential word;
- jump to a 27-bit constant, either as an absolute target or as an offset from the PC;
- jump through register B plus a signed 16-bit offset, either as an absolute target or as an offset from the PC;
- take or skip a conditional branch;
- hold at the current address (halt);
- resume at the saved return address of an interrupt.

The PC counts instruction words, not bytes.

The instruction stream has a valid qualifier and no back-pressure. The unit accepts a word in every cycle in which `instr_valid` is high. In a cycle with `instr_valid` low the PC holds.

An interrupt request (`irq_take` with `irq_vec`) overrides the instruction in the same cycle, so it can also break out of a halt. `next_pc` and `taken` are combinational and describe the decision for the current word. `pc` is the registered result.

Top module: `npc_unit`

## Requirements
- R1: After reset, `pc` equals the parameter RESET_PC (default 0).
- R2: A valid word whose bits [31:28] match none of 1001, 1000, 0110, 1111, 0100 advances `pc` by 1 and drives `taken` low.
- R3: Format 1001 is a constant jump with constant C = bits [27:1] and mode = bit 0. Mode 0 loads C, zero-extended, into `pc`. Mode 1 adds C, sign-extended from bit 26, to `pc`. `taken` is high.
- R4: Format 1000 is a register jump. It forms T = B + the sign-extended offset in bits [27:12]. Mode bit 0 clear loads T into `pc`; set adds T to `pc`. `taken` is high.
- R5: Format 0110 is a branch. It compares A with B using the code in bits [3:1]: 000 equal, 001 greater, 010 greater-or-equal, 100 not-equal, 101 less, 110 less-or-equal. When the relation holds, `pc` gains the sign-extended offset in bits [27:12] and `taken` is high. Otherwise `pc` advances by 1.
- R6: Branch bit 0 set selects a signed (two's complement) compare; clear selects an unsigned compare.
- R7: Branch codes 011 and 111 are never taken.
- R8: Format 1111 (halt) keeps `pc` unchanged and drives `taken` high.
- R9: `irq_take` high loads `irq_vec` into `pc` and overrides any instruction, including halt.
- R10: Format 0100 loads `epc` into `pc` and pulses `irq_en_set` for that cycle, unless `irq_take` is also high.
- R11: With `instr_valid` low and `irq_take` low, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| reg_a | input | 32 | Value of source register A |
| reg_b | input | 32 | Value of source register B |
| epc | input | 32 | Saved interrupt return address |
| irq_take | input | 1 | Interrupt redirect this cycle |
| irq_vec | input | 32 | Interrupt handler address |
| pc | output | 32 | Registered program counter |
| next_pc | output | 32 | Instruction-selected next PC (combinational) |
| taken | output | 1 | Next PC is not the sequential one |
| irq_en_set | output | 1 | Interrupt-return pulse that re-enables interrupts |

## Verification
The only state is the PC register, so a wrong decision shows at `pc` one clock after the word that caused it. Every later relative target is then shifted by the same error. A bad compare or mode decode also shows on `taken` in the same cycle as the word. The scoreboard tracks its own PC model step by step, so the first wrong cycle is reported with the failing requirement.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    FMT_JUMPC  = 4'b1001,
    FMT_JUMPR  = 4'b1000,
    FMT_BRANCH = 4'b0110,
    FMT_HALT   = 4'b1111,
    FMT_RETI   = 4'b0100
  } fmt_e;

  typedef enum logic [2:0] {
    CMP_EQ = 3'b000,
    CMP_GT = 3'b001,
    CMP_GE = 3'b010,
    CMP_NE = 3'b100,
    CMP_LT = 3'b101,
    CMP_LE = 3'b110
  } cmp_e;

  localparam int OFS_W = 16;
  localparam int JC_W  = 27;
endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      code,
  input  logic            sgn,
  output logic            pass
);
  import npc_pkg::*;
  logic eq, lt;

  always_comb begin
    eq = (a == b);
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    case (code)
      CMP_EQ:  pass = eq;
      CMP_GT:  pass = !lt && !eq;
      CMP_GE:  pass = !lt;
      CMP_NE:  pass = !eq;
      CMP_LT:  pass = lt;
      CMP_LE:  pass = lt || eq;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]          pc,
  input  logic [XLEN-1:0]          reg_b,
  input  logic [npc_pkg::JC_W-1:0] jc,
  input  logic [npc_pkg::OFS_W-1:0] ofs,
  input  logic                     mode,
  output logic [XLEN-1:0]          seq_tgt,
  output logic [XLEN-1:0]          jc_tgt,
  output logic [XLEN-1:0]          jr_tgt,
  output logic [XLEN-1:0]          br_tgt
);
  import npc_pkg::*;
  localparam int JC_PAD  = XLEN - JC_W;
  localparam int OFS_PAD = XLEN - OFS_W;

  logic [XLEN-1:0] ofs_sx, jc_sx, jc_zx, rb_sum;

  always_comb begin
    ofs_sx  = {{OFS_PAD{ofs[OFS_W-1]}}, ofs};
    jc_sx   = {{JC_PAD{jc[JC_W-1]}}, jc};
    jc_zx   = {{JC_PAD{1'b0}}, jc};
    rb_sum  = reg_b + ofs_sx;
    seq_tgt = pc + XLEN'(1);
    jc_tgt  = mode ? (pc + jc_sx) : jc_zx;
    jr_tgt  = mode ? (pc + rb_sum) : rb_sum;
    br_tgt  = pc + ofs_sx;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] reg_a,
  input  logic [XLEN-1:0] reg_b,
  input  logic [XLEN-1:0] epc,
  input  logic            irq_take,
  input  logic [XLEN-1:0] irq_vec,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            irq_en_set
);
  import npc_pkg::*;

  logic [3:0]      fmt;
  logic            br_pass;
  logic [XLEN-1:0] seq_tgt, jc_tgt, jr_tgt, br_tgt;
  logic            is_reti;

  assign fmt = instr[31:28];

  npc_cmp #(.XLEN(XLEN)) u_cmp (
    .a    (reg_a),
    .b    (reg_b),
    .code (instr[3:1]),
    .sgn  (instr[0]),
    .pass (br_pass)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc      (pc),
    .reg_b   (reg_b),
    .jc      (instr[JC_W:1]),
    .ofs     (instr[27:12]),
    .mode    (instr[0]),
    .seq_tgt (seq_tgt),
    .jc_tgt  (jc_tgt),
    .jr_tgt  (jr_tgt),
    .br_tgt  (br_tgt)
  );

  always_comb begin
    next_pc = seq_tgt;
    taken   = 1'b0;
    is_reti = 1'b0;
    if (instr_valid) begin
      case (fmt)
        FMT_JUMPC:  begin next_pc = jc_tgt; taken = 1'b1; end
        FMT_JUMPR:  begin next_pc = jr_tgt; taken = 1'b1; end
        FMT_BRANCH: begin
          taken = br_pass;
          if (br_pass) next_pc = br_tgt;
        end
        FMT_HALT:   begin next_pc = pc;  taken = 1'b1; end
        FMT_RETI:   begin next_pc = epc; taken = 1'b1; is_reti = 1'b1; end
        default:    ;
      endcase
    end
  end

  assign irq_en_set = is_reti && !irq_take;

  always_ff @(posedge clk) begin
    if (!rst_n)           pc <= XLEN'(RESET_PC);
    else if (irq_take)    pc <= irq_vec;
    else if (instr_valid) pc <= next_pc;
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] epc,
  input logic            irq_take,
  input logic [XLEN-1:0] irq_vec,
  input logic [XLEN-1:0] pc,
  input logic            taken,
  input logic            irq_en_set
);
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !irq_take && !taken) |=> pc == $past(pc) + XLEN'(1));

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[31:28] == 4'b0110 && instr[2:1] == 2'b11) |-> !taken);

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[31:28] == 4'b1111 && !irq_take) |=> pc == $past(pc));

  p_irq_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc == $past(irq_vec));

  p_reti_epc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[31:28] == 4'b0100 && !irq_take) |=> pc == $past(epc));

  p_reti_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_set |-> (instr_valid && !irq_take));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !irq_take) |=> $stable(pc));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .epc         (epc),
  .irq_take    (irq_take),
  .irq_vec     (irq_vec),
  .pc          (pc),
  .taken       (taken),
  .irq_en_set  (irq_en_set)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0, reg_a = '0, reg_b = '0, epc = '0, irq_vec = '0;
  logic        irq_take = 1'b0;
  logic [31:0] pc, next_pc;
  logic        taken, irq_en_set;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_pc = 32'h0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .reg_a(reg_a), .reg_b(reg_b), .epc(epc), .irq_take(irq_take),
    .irq_vec(irq_vec), .pc(pc), .next_pc(next_pc), .taken(taken),
    .irq_en_set(irq_en_set)
  );

  function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  function automatic logic [31:0] enc_br(logic [15:0] ofs, logic [2:0] code, logic sgn);
    return {4'b0110, ofs, 4'h1, 4'h2, code, sgn};
  endfunction
  function automatic logic [31:0] enc_jc(logic [26:0] c, logic mode);
    return {4'b1001, c, mode};
  endfunction
  function automatic logic [31:0] enc_jr(logic [15:0] ofs, logic mode);
    return {4'b1000, ofs, 4'h0, 4'h3, 3'b000, mode};
  endfunction

  function automatic bit rel(logic [2:0] code, logic sgn, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    sa = sgn ? longint'($signed(a)) : longint'({32'h0, a});
    sb = sgn ? longint'($signed(b)) : longint'({32'h0, b});
    case (code)
      3'd0: return sa == sb;
      3'd1: return sa > sb;
      3'd2: return sa >= sb;
      3'd4: return sa != sb;
      3'd5: return sa < sb;
      3'd6: return sa <= sb;
      default: return 1'b0;
    endcase
  endfunction

  // Independent model: returns {taken, next}
  function automatic logic [32:0] model(logic [31:0] p, logic [31:0] w,
                                        logic [31:0] a, logic [31:0] b, logic [31:0] e);
    logic [31:0] o16;
    logic [31:0] t;
    o16 = 32'($signed(w[27:12]));
    case (w[31:28])
      4'b1001: return w[0] ? {1'b1, p + 32'($signed(w[27:1]))} : {1'b1, 5'b0, w[27:1]};
      4'b1000: begin
        t = b + o16;
        return w[0] ? {1'b1, p + t} : {1'b1, t};
      end
      4'b0110: return rel(w[3:1], w[0], a, b) ? {1'b1, p + o16} : {1'b0, p + 32'd1};
      4'b1111: return {1'b1, p};
      4'b0100: return {1'b1, e};
      default: return {1'b0, p + 32'd1};
    endcase
  endfunction

  task automatic step(string req, logic v, logic [31:0] w, logic [31:0] a,
                      logic [31:0] b, logic irq = 1'b0, logic [31:0] vec = 32'h0);
    logic [32:0] m;
    @(negedge clk);
    instr_valid = v; instr = w; reg_a = a; reg_b = b;
    irq_take = irq; irq_vec = vec;
    #1;
    m = model(m_pc, w, a, b, epc);
    if (v) chk({req, " taken"}, {31'h0, taken}, {31'h0, m[32]});
    chk({req, " irq_en_set"}, {31'h0, irq_en_set},
        {31'h0, v && !irq && w[31:28] == 4'b0100});
    if (irq)    m_pc = vec;
    else if (v) m_pc = m[31:0];
    exp_q.push_back(m_pc);
    tag_q.push_back(req);
  endtask

  // Monitor: compare registered pc against scoreboard after each edge
  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), pc, exp_q.pop_front());
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset pc", pc, 32'h0);
    // R2 sequential
    step("R2", 1, 32'h3000_1234, 0, 0);
    step("R2", 1, 32'h0000_0000, 0, 0);
    // R5 unsigned relations
    step("R5 beq", 1, enc_br(16'd10, 3'd0, 0), 32'd7, 32'd7);
    step("R5 bne eq", 1, enc_br(16'd10, 3'd4, 0), 32'd7, 32'd7);
    step("R5 bgt u", 1, enc_br(-16'sd3, 3'd1, 0), 32'hFFFF_FFFF, 32'd1);
    // R6 signed
    step("R6 bgt s", 1, enc_br(16'd4, 3'd1, 1), 32'hFFFF_FFFF, 32'd1);
    step("R6 blt s", 1, enc_br(16'd5, 3'd5, 1), 32'hFFFF_FFFF, 32'd1);
    step("R6 blt u", 1, enc_br(16'd5, 3'd5, 0), 32'hFFFF_FFFF, 32'd1);
    step("R5 bge", 1, enc_br(16'd2, 3'd2, 0), 32'd9, 32'd9);
    step("R5 ble", 1, enc_br(16'd2, 3'd6, 1), 32'h8000_0000, 32'd0);
    // R7 reserved
    step("R7 c3", 1, enc_br(16'd20, 3'd3, 0), 32'd1, 32'd1);
    step("R7 c7", 1, enc_br(16'd20, 3'd7, 1), 32'd1, 32'd2);
    // R3 constant jumps
    step("R3 abs", 1, enc_jc(27'h100, 0), 0, 0);
    step("R3 rel", 1, enc_jc(-27'sd16, 1), 0, 0);
    step("R3 abs hi", 1, enc_jc(27'h400_0000, 0), 0, 0);
    step("R3 abs", 1, enc_jc(27'h100, 0), 0, 0);
    // R4 register jumps
    step("R4 abs", 1, enc_jr(-16'sd4, 0), 0, 32'h200);
    step("R4 rel", 1, enc_jr(16'd2, 1), 0, 32'd8);
    // R8 halt
    step("R8", 1, 32'hFFFF_FFFF, 0, 0);
    step("R8", 1, 32'hFFFF_FFFF, 0, 0);
    // R9 interrupt breaks halt
    step("R9", 1, 32'hFFFF_FFFF, 0, 0, 1'b1, 32'h300);
    // R11 idle
    step("R11", 0, enc_jc(27'h55, 0), 0, 0);
    step("R11", 0, 32'h0, 0, 0);
    // R10 return from interrupt
    epc = 32'h0000_0207;
    step("R10", 1, 32'h4000_0000, 0, 0);
    step("R10 irq over reti", 1, 32'h4000_0000, 0, 0, 1'b1, 32'h500);
    step("R2", 1, 32'h2000_0000, 0, 0);
    @(negedge clk);
    instr_valid = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule